// File: doc/BRIEF.md
# Reset Source Status Controller

This block merges four reset requests into one internal reset line: a normal power-on, a power-on during which the backup supply was found missing, the external reset pin, and a watchdog timeout. The internal reset follows the requests. It stays asserted while any request is present and drops one cycle after the last one goes away. While the internal reset is active, a control output puts the address-latch and program-strobe pins into input direction.

Three status bits share one register, so software can tell which reset happened last. The bits follow different rules:

- The power-on flag is cleared by any power-on, and only software can set it.
- The watchdog flag is set by a timeout. Hardware clears it once the register has been read.
- The watchdog-enable bit is lost only when a power-on finds the backup supply missing.

The power-on flag and the enable bit accept writes only inside a short timed-access window. Software opens that window by writing a two-byte key to an unlock address.

Top module: `rst_src_ctrl`

## Requirements
- R1: If any of the four request inputs is high at a rising clock edge, `irst_o` is high after that edge.
- R2: `irst_o` stays high for as long as a request persists. It goes low after the first edge at which all four requests are low.
- R3: `pins_in_o` is high in every cycle in which `irst_o` is high, and low otherwise.
- R4: The power-on flag (status bit 2) is 0 after an edge at which either power-on request is high. The external reset and the watchdog timeout leave it unchanged.
- R5: A write to the status address (1) loads the power-on flag from write-data bit 2 only while the timed-access window is open. A write outside the window has no effect on it.
- R6: The watchdog flag (status bit 1) becomes 1 after an edge at which `wdt_to_i` is high. Power-on requests and the external reset leave it unchanged.
- R7: A read of the status address returns the watchdog flag's current value, and the flag is 0 after that edge. If `wdt_to_i` is high at the same edge, the flag stays 1.
- R8: Writes never change the watchdog flag, even when they land inside the timed-access window.
- R9: The watchdog-enable bit (status bit 0) is cleared only by the backup-missing power-on. It keeps its value through the plain power-on, the external reset and the watchdog timeout.
- R10: A write to the status address loads the enable bit from write-data bit 0 only while the window is open. A write outside the window has no effect on it.
- R11: The window opens only after a write of 8'hAA to the unlock address (2), followed by the next write being 8'h55 to that same address. Any other write in between cancels the sequence.
- R12: Writes sampled at the 1st through 4th edges after the edge that took the 8'h55 key are inside the window. A write at the 5th edge is outside it.
- R13: The first status write inside the window closes it, so a second write in the same window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| pwr_plain_i | input | 1 | Power-on request with backup supply present |
| pwr_nobk_i | input | 1 | Power-on request with backup supply missing |
| ext_rst_i | input | 1 | External reset pin request |
| wdt_to_i | input | 1 | Watchdog timeout request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data: status bits at the status address, zero elsewhere |
| irst_o | output | 1 | Internal reset line |
| pins_in_o | output | 1 | High: address-latch and program-strobe pins set to input |

## Verification
The bench builds the block with its defaults: `WINDOW_CYC` = 4, the registered reset output, status address 1 and unlock address 2. With a four-cycle window, the bench can place protected writes exactly on the last open edge and on the first closed edge. The 8-bit data path lets it send the real key bytes and near-miss values. With the registered reset variant, the bench can check the one-edge delay of `irst_o` on both assertion and release. It can also line up a watchdog timeout with a read strobe at the same edge to confirm that the set wins.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;

   typedef enum logic [1:0] {
      TA_IDLE  = 2'd0,
      TA_ARMED = 2'd1,
      TA_OPEN  = 2'd2
   } ta_state_e;

   typedef struct packed {
      logic por;
      logic wdt;
      logic en;
   } rst_flags_t;

endpackage

// File: rtl/rst_src_combiner.sv
module rst_src_combiner #(
   parameter bit IRST_REG = 1'b1
) (
   input  logic clk_i,
   input  logic pwr_plain_i,
   input  logic pwr_nobk_i,
   input  logic ext_rst_i,
   input  logic wdt_to_i,
   output logic any_req_o,
   output logic irst_o,
   output logic pins_in_o
);

   assign any_req_o = pwr_plain_i | pwr_nobk_i | ext_rst_i | wdt_to_i;

   generate
      if (IRST_REG) begin : g_reg
         logic irst_q;
         logic pins_q;
         always_ff @(posedge clk_i) begin
            irst_q <= any_req_o;
            pins_q <= any_req_o;
         end
         assign irst_o    = irst_q;
         assign pins_in_o = pins_q;

         assert_irst_set_R1: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
            any_req_o |=> irst_o);
         assert_irst_release_R2: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
            !any_req_o |=> !irst_o);
         assert_pins_follow_R3: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
            any_req_o |=> pins_in_o);
      end else begin : g_comb
         assign irst_o    = any_req_o;
         assign pins_in_o = any_req_o;
      end
   endgenerate

endmodule

// File: rtl/rst_src_unlock.sv
module rst_src_unlock
   import rst_src_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned UNLOCK_ADDR = 2,
   parameter int unsigned KEY_FIRST   = 8'hAA,
   parameter int unsigned KEY_SECOND  = 8'h55,
   parameter int unsigned WINDOW_CYC  = 4
) (
   input  logic              clk_i,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              prot_wr_i,
   output logic              open_o
);

   localparam int unsigned CNT_W = $clog2(WINDOW_CYC + 1);

   ta_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hit_addr;
   logic             key1_wr;
   logic             key2_wr;

   assign hit_addr = wr_en_i && (addr_i == ADDR_W'(UNLOCK_ADDR));
   assign key1_wr  = hit_addr && (wdata_i == DATA_W'(KEY_FIRST));
   assign key2_wr  = hit_addr && (wdata_i == DATA_W'(KEY_SECOND));

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         state_q <= TA_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            TA_IDLE: begin
               if (key1_wr) state_q <= TA_ARMED;
            end
            TA_ARMED: begin
               if (wr_en_i) begin
                  if (key2_wr) begin
                     state_q <= TA_OPEN;
                     cnt_q   <= CNT_W'(WINDOW_CYC);
                  end else if (!key1_wr) begin
                     state_q <= TA_IDLE;
                  end
               end
            end
            TA_OPEN: begin
               if (prot_wr_i || cnt_q == CNT_W'(1)) begin
                  state_q <= TA_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: state_q <= TA_IDLE;
         endcase
      end
   end

   assign open_o = (state_q == TA_OPEN);

   assert_open_needs_key_R11: assert property (@(posedge clk_i) disable iff (clr_i)
      $rose(open_o) |-> $past(key2_wr));
   assert_close_on_write_R13: assert property (@(posedge clk_i) disable iff (clr_i)
      (open_o && prot_wr_i) |=> !open_o);

endmodule

// File: rtl/rst_src_flags.sv
module rst_src_flags
   import rst_src_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned POR_BIT = 2,
   parameter int unsigned EN_BIT  = 0
) (
   input  logic              clk_i,
   input  logic              pwr_any_i,
   input  logic              pwr_nobk_i,
   input  logic              ext_rst_i,
   input  logic              wdt_to_i,
   input  logic              stat_wr_i,
   input  logic              stat_rd_i,
   input  logic              open_i,
   input  logic [DATA_W-1:0] wdata_i,
   output rst_flags_t        flags_o
);

   rst_flags_t flg_q;
   logic       wr_ok;

   assign wr_ok = stat_wr_i && open_i;

   always_ff @(posedge clk_i) begin
      if (pwr_any_i)  flg_q.por <= 1'b0;
      else if (wr_ok) flg_q.por <= wdata_i[POR_BIT];

      if (pwr_nobk_i) flg_q.en <= 1'b0;
      else if (wr_ok) flg_q.en <= wdata_i[EN_BIT];

      if (wdt_to_i)       flg_q.wdt <= 1'b1;
      else if (stat_rd_i) flg_q.wdt <= 1'b0;
   end

   assign flags_o = flg_q;

   assert_por_clear_R4: assert property (@(posedge clk_i) disable iff (ext_rst_i)
      pwr_any_i |=> !flags_o.por);
   assert_por_locked_R5: assert property (@(posedge clk_i) disable iff (pwr_any_i)
      !open_i |=> $stable(flags_o.por));
   assert_wdt_set_R6: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
      wdt_to_i |=> flags_o.wdt);
   assert_wdt_clear_R7: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
      (stat_rd_i && !wdt_to_i) |=> !flags_o.wdt);
   assert_wdt_no_write_R8: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
      (!wdt_to_i && !stat_rd_i) |=> $stable(flags_o.wdt));
   assert_en_clear_R9: assert property (@(posedge clk_i) disable iff (ext_rst_i)
      pwr_nobk_i |=> !flags_o.en);
   assert_en_locked_R10: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
      !open_i |=> $stable(flags_o.en));

endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
   import rst_src_pkg::*;
#(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STAT_ADDR   = 1,
   parameter int unsigned UNLOCK_ADDR = 2,
   parameter int unsigned POR_BIT     = 2,
   parameter int unsigned WDT_BIT     = 1,
   parameter int unsigned EN_BIT      = 0,
   parameter int unsigned WINDOW_CYC  = 4,
   parameter bit          IRST_REG    = 1'b1
) (
   input  logic              clk_i,
   input  logic              pwr_plain_i,
   input  logic              pwr_nobk_i,
   input  logic              ext_rst_i,
   input  logic              wdt_to_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irst_o,
   output logic              pins_in_o
);

   localparam int unsigned KEY_A = 8'hAA;
   localparam int unsigned KEY_B = 8'h55;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("rst_src_ctrl: DATA_W must hold the 8-bit unlock key");
      end
      if (WINDOW_CYC < 1) begin : g_bad_window
         $error("rst_src_ctrl: WINDOW_CYC must be at least 1");
      end
      if (STAT_ADDR == UNLOCK_ADDR) begin : g_bad_addr
         $error("rst_src_ctrl: status and unlock addresses must differ");
      end
      if (POR_BIT == WDT_BIT || POR_BIT == EN_BIT || WDT_BIT == EN_BIT) begin : g_bad_bits
         $error("rst_src_ctrl: status bit positions must be distinct");
      end
      if (POR_BIT >= DATA_W || WDT_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_bad_pos
         $error("rst_src_ctrl: status bit position outside data width");
      end
   endgenerate

   logic       any_req;
   logic       pwr_any;
   logic       hit_stat;
   logic       stat_wr;
   logic       stat_rd;
   logic       win_open;
   rst_flags_t flags;

   assign pwr_any  = pwr_plain_i | pwr_nobk_i;
   assign hit_stat = (reg_addr_i == ADDR_W'(STAT_ADDR));
   assign stat_wr  = reg_wr_i && hit_stat;
   assign stat_rd  = reg_rd_i && hit_stat;

   rst_src_combiner #(
      .IRST_REG (IRST_REG)
   ) u_comb (
      .clk_i       (clk_i),
      .pwr_plain_i (pwr_plain_i),
      .pwr_nobk_i  (pwr_nobk_i),
      .ext_rst_i   (ext_rst_i),
      .wdt_to_i    (wdt_to_i),
      .any_req_o   (any_req),
      .irst_o      (irst_o),
      .pins_in_o   (pins_in_o)
   );

   rst_src_unlock #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .UNLOCK_ADDR (UNLOCK_ADDR),
      .KEY_FIRST   (KEY_A),
      .KEY_SECOND  (KEY_B),
      .WINDOW_CYC  (WINDOW_CYC)
   ) u_unlock (
      .clk_i     (clk_i),
      .clr_i     (any_req),
      .wr_en_i   (reg_wr_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .prot_wr_i (stat_wr),
      .open_o    (win_open)
   );

   rst_src_flags #(
      .DATA_W  (DATA_W),
      .POR_BIT (POR_BIT),
      .EN_BIT  (EN_BIT)
   ) u_flags (
      .clk_i      (clk_i),
      .pwr_any_i  (pwr_any),
      .pwr_nobk_i (pwr_nobk_i),
      .ext_rst_i  (ext_rst_i),
      .wdt_to_i   (wdt_to_i),
      .stat_wr_i  (stat_wr),
      .stat_rd_i  (stat_rd),
      .open_i     (win_open),
      .wdata_i    (reg_wdata_i),
      .flags_o    (flags)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (hit_stat) begin
         reg_rdata_o[POR_BIT] = flags.por;
         reg_rdata_o[WDT_BIT] = flags.wdt;
         reg_rdata_o[EN_BIT]  = flags.en;
      end
   end

   assert_pins_match_R3: assert property (@(posedge clk_i) disable iff (pwr_nobk_i)
      pins_in_o == irst_o);

endmodule

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
   localparam logic [ADDR_W-1:0] A_UNLK = 4'd2;

   logic              clk = 1'b0;
   logic              pwr_plain = 1'b0;
   logic              pwr_nobk  = 1'b0;
   logic              ext_rst   = 1'b0;
   logic              wdt_to    = 1'b0;
   logic              reg_wr    = 1'b0;
   logic              reg_rd    = 1'b0;
   logic [ADDR_W-1:0] reg_addr  = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              irst;
   logic              pins_in;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   logic [DATA_W-1:0] exp_q[$];
   logic [DATA_W-1:0] mask_q[$];
   string             tag_q[$];

   always #2.5 clk = ~clk;

   rst_src_ctrl u_rst_src_ctrl (
      .clk_i       (clk),
      .pwr_plain_i (pwr_plain),
      .pwr_nobk_i  (pwr_nobk),
      .ext_rst_i   (ext_rst),
      .wdt_to_i    (wdt_to),
      .reg_wr_i    (reg_wr),
      .reg_rd_i    (reg_rd),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irst_o      (irst),
      .pins_in_o   (pins_in)
   );

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // called right after a falling edge
   task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic bus_rd(input logic [DATA_W-1:0] exp, input logic [DATA_W-1:0] msk,
                         input string tag);
      exp_q.push_back(exp); mask_q.push_back(msk); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = A_STAT;
      @(negedge clk);
      reg_rd = 1'b0; reg_addr = '0;
   endtask

   task automatic unlock();
      bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_UNLK, 8'h55);
   endtask

   task automatic pulse(input int which, input int cyc);
      case (which)
         0: pwr_plain = 1'b1;
         1: pwr_nobk  = 1'b1;
         2: ext_rst   = 1'b1;
         default: wdt_to = 1'b1;
      endcase
      repeat (cyc) @(negedge clk);
      pwr_plain = 1'b0; pwr_nobk = 1'b0; ext_rst = 1'b0; wdt_to = 1'b0;
      @(negedge clk);
   endtask

   // monitor: compares read data against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (reg_rd) begin
            logic [DATA_W-1:0] e, m;
            string t;
            if (exp_q.size() == 0) begin
               checks++; failures++;
               $display("FAIL scoreboard: actual=%02h expected=<none>", reg_rdata);
            end else begin
               e = exp_q.pop_front(); m = mask_q.pop_front(); t = tag_q.pop_front();
               checks++;
               if ((reg_rdata & m) !== (e & m)) begin
                  failures++;
                  $display("FAIL %s: actual=%02h expected=%02h mask=%02h", t, reg_rdata, e, m);
               end
            end
         end
      end
   end

   initial begin
      @(negedge clk);
      // power-on with backup missing
      pwr_nobk = 1'b1;
      @(negedge clk);
      check_bit("R1 irst after request", irst, 1'b1);
      check_bit("R3 pins input in reset", pins_in, 1'b1);
      @(negedge clk); @(negedge clk);
      check_bit("R2 irst held", irst, 1'b1);
      pwr_nobk = 1'b0;
      @(negedge clk);
      check_bit("R2 irst released", irst, 1'b0);
      check_bit("R3 pins released", pins_in, 1'b0);
      bus_rd(8'h00, 8'h05, "R4 R9 reset state");

      // locked writes
      bus_wr(A_STAT, 8'hFF);
      bus_rd(8'h00, 8'h05, "R5 R10 write outside window");

      // unlocked write
      unlock();
      bus_wr(A_STAT, 8'h05);
      bus_wr(A_STAT, 8'h00);
      bus_rd(8'h05, 8'h05, "R13 second write ignored, R5 R10 first taken");

      // watchdog timeout
      wdt_to = 1'b1;
      @(negedge clk);
      check_bit("R1 irst on timeout", irst, 1'b1);
      wdt_to = 1'b0;
      @(negedge clk);
      bus_rd(8'h07, 8'hFF, "R6 wdt set, R4 R9 kept");
      bus_rd(8'h05, 8'hFF, "R7 cleared after read");

      // writes cannot touch wdt flag
      pulse(3, 1);
      unlock();
      bus_wr(A_STAT, 8'h04);
      bus_rd(8'h06, 8'hFF, "R8 wdt not writable");
      bus_rd(8'h04, 8'hFF, "R7 clear again");
      unlock();
      bus_wr(A_STAT, 8'h05);

      // set wins over clear at the same edge
      pulse(3, 1);
      wdt_to = 1'b1;
      bus_rd(8'h07, 8'hFF, "R7 read with timeout");
      wdt_to = 1'b0;
      bus_rd(8'h07, 8'hFF, "R7 set wins");
      bus_rd(8'h05, 8'hFF, "R7 cleared after");

      // external reset leaves flags alone
      ext_rst = 1'b1;
      @(negedge clk);
      check_bit("R1 irst on pin", irst, 1'b1);
      ext_rst = 1'b0;
      @(negedge clk);
      check_bit("R2 irst released after pin", irst, 1'b0);
      bus_rd(8'h05, 8'hFF, "R4 R6 R9 pin reset keeps flags");

      // window length
      unlock();
      repeat (3) @(negedge clk);
      bus_wr(A_STAT, 8'h01);
      bus_rd(8'h01, 8'hFF, "R12 write on 4th window cycle");
      unlock();
      repeat (4) @(negedge clk);
      bus_wr(A_STAT, 8'h05);
      bus_rd(8'h01, 8'hFF, "R12 write on 5th cycle ignored");

      // broken key sequence
      bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_UNLK, 8'h11);
      bus_wr(A_UNLK, 8'h55);
      bus_wr(A_STAT, 8'h05);
      bus_rd(8'h01, 8'hFF, "R11 broken sequence no window");
      bus_wr(A_UNLK, 8'hAA);
      bus_wr(A_STAT, 8'h05);
      bus_wr(A_UNLK, 8'h55);
      bus_wr(A_STAT, 8'h05);
      bus_rd(8'h01, 8'hFF, "R11 key interrupted by other write");

      // set por then plain power-on
      unlock();
      bus_wr(A_STAT, 8'h05);
      bus_rd(8'h05, 8'hFF, "R5 por set by software");
      pulse(0, 2);
      bus_rd(8'h01, 8'hFF, "R4 plain power-on clears por, R9 keeps en");
      pulse(1, 2);
      bus_rd(8'h00, 8'hFF, "R9 backup-missing power-on clears en");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule